// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

This block decides which interrupt source the processor should service first. Software loads a table of priority slots through a simple register port. Each slot holds an enable flag and a source number. The interrupt routing logic supplies three per-source vectors: pending, enabled and fast-select.

From the table and these vectors, the block finds two winners with no clock in between. One is the best asserted source on the fast class. The other is the best asserted source on the normal class. Software reads both at once from a single 32-bit status word.

Priority comes from slot position, not from the source number. A lower slot index wins over a higher one. Software can therefore reorder sources freely. A source may also sit in more than one slot, and the lowest matching slot decides. The status word is built combinationally from the current table and vectors. A read therefore always reflects the state in the same cycle.

Top module: `prio_resolver`

## Requirements
- R1: After synchronous active-low reset every slot is empty (flag clear, source 0). Every slot reads as 0x00000000, and the status word reads 0x003F003F.
- R2: Slot k (0..31) is at byte offset 0x1C + 4k. Slot k (32..39) is at byte offset 0xB0 + 4(k-32). A write there changes that slot only, and a read there returns it.
- R3: A slot write keeps bit 31 as the slot flag and bits 5:0 as the source number. Bits 30:6 of a slot always read as zero.
- R4: A slot competes only when its flag is set and its source number is below 40. Slots with a source of 40..63, or with the flag clear, are skipped.
- R5: Among competing slots whose source is asserted in a class, the one with the lowest slot index wins. This holds also when the same source fills several slots.
- R6: A source is asserted when both its pending and its enabled bit are 1. A fast-select bit of 1 puts it in the fast class, and 0 puts it in the normal class.
- R7: Status bits 15:0 report the fast winner: bit 15 is the found flag, bits 5:0 are the source, and bits 14:6 are zero. Status bits 31:16 report the normal winner: bit 31 is the found flag, bits 21:16 are the source, and bits 30:22 are zero.
- R8: A class with no winner reads 0x003F in its half, with the found flag clear.
- R9: The status word is read at offset 0x18. It follows the current table and vectors in the same cycle, with no clock edge needed.
- R10: Writes to any other offset, to 0x18, or to an unaligned address have no effect. Reads there return zero (except 0x18).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| src_pending | input | 40 | Per-source pending bits |
| src_enable | input | 40 | Per-source enable bits |
| src_fast | input | 40 | Per-source class select, 1 = fast |

## Verification
The hardest case to reach from the ports is a conflict between several slots. Two slots may name different sources that are asserted in the same class. The same source may sit in two slots. A slot may name a source number of 40 or more. Each of these changes which slot wins.

The bench reaches these cases in stages:
- It first loads an identity table and sweeps every single source through both classes.
- It then loads a reversed table and drives every ordered pair of sources, with the class chosen from the pair.
- It places out-of-range, disabled and duplicated entries ahead of legal ones.
- It finishes with pseudo-random table rewrites and vectors.

Every result is compared against a slot-by-slot model kept in the bench.

// File: rtl/prio_pkg.sv
// Package: shared constants and the slot record for the priority resolver.
// Assumes an 8-bit byte-offset register port and 32-bit data.
package prio_pkg;
    localparam int unsigned SRC_W      = 6;
    localparam int unsigned HALF_W     = 16;
    localparam int unsigned FLAG_BIT   = 31;
    localparam int unsigned STATUS_OFS = 8'h18;
    localparam int unsigned LOW_BASE   = 8'h1C;
    localparam int unsigned HIGH_BASE  = 8'hB0;
    localparam int unsigned STRIDE     = 4;

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] src;
    } slot_t;
endpackage

// File: rtl/prio_slot_table.sv
// Module: holds the priority slot registers, decodes slot offsets and
// returns the read-back word of the addressed slot.
// Assumes slots are split into a low bank and a high bank at two bases.
module prio_slot_table
    import prio_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 40,
    parameter int unsigned LOW_BANK  = 32,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    output slot_t [NUM_SLOTS-1:0] slots,
    output logic                  hit,
    output logic [31:0]           rd_word
);
    localparam int unsigned IDX_W     = $clog2(NUM_SLOTS);
    localparam int unsigned HIGH_BANK = NUM_SLOTS - LOW_BANK;
    localparam int unsigned LOW_END   = LOW_BASE + STRIDE * LOW_BANK;
    localparam int unsigned HIGH_END  = HIGH_BASE + STRIDE * HIGH_BANK;

    logic [IDX_W-1:0] idx;

    // Decode: map an aligned byte offset onto a slot index.
    always_comb begin
        int unsigned a;
        a   = 32'(addr);
        hit = 1'b0;
        idx = '0;
        if (addr[1:0] == 2'b00) begin
            if (a >= LOW_BASE && a < LOW_END) begin
                hit = 1'b1;
                idx = IDX_W'((a - LOW_BASE) / STRIDE);
            end else if (a >= HIGH_BASE && a < HIGH_END) begin
                hit = 1'b1;
                idx = IDX_W'(LOW_BANK + (a - HIGH_BASE) / STRIDE);
            end
        end
    end

    // Storage: one register per slot, cleared by reset, written when addressed.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[g] <= '0;
            end else if (wr_en && hit && idx == IDX_W'(g)) begin
                slots[g].valid <= wdata[FLAG_BIT];
                slots[g].src   <= wdata[SRC_W-1:0];
            end
        end
    end

    // Read-back: flag at the top, source at the bottom, zeros between.
    always_comb begin
        rd_word = '0;
        if (hit) begin
            rd_word[FLAG_BIT]    = slots[idx].valid;
            rd_word[SRC_W-1:0]   = slots[idx].src;
        end
    end

    AST_SLOT_WRITE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit) |=> (slots[$past(idx)].valid == $past(wdata[FLAG_BIT])
                         && slots[$past(idx)].src == $past(wdata[SRC_W-1:0]))); // R3
endmodule

// File: rtl/prio_winner_scan.sv
// Module: scans all slots and picks the lowest-index slot whose source is a
// candidate. Reports found and the winning source (all ones when none).
// Assumes the candidate vector is already restricted to one class.
module prio_winner_scan
    import prio_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 40,
    parameter int unsigned NUM_SRC   = 40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  slot_t [NUM_SLOTS-1:0] slots,
    input  logic [NUM_SRC-1:0]    cand,
    output logic                  found,
    output logic [SRC_W-1:0]      win_src
);
    // Priority chain: walk from the last slot down so the lowest index wins.
    always_comb begin
        found   = 1'b0;
        win_src = '1;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (slots[i].valid && 32'(slots[i].src) < NUM_SRC) begin
                if (cand[slots[i].src]) begin
                    found   = 1'b1;
                    win_src = slots[i].src;
                end
            end
        end
    end

    AST_WINNER_ASSERTED: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (32'(win_src) < NUM_SRC && cand[win_src])); // R6
    AST_NO_WINNER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (win_src == '1)); // R8
endmodule

// File: rtl/prio_status_pack.sv
// Module: packs the fast and normal winners into the 32-bit status word.
// Assumes each winner source is all ones when its found flag is clear.
module prio_status_pack
    import prio_pkg::*;
(
    input  logic             fast_found,
    input  logic [SRC_W-1:0] fast_src,
    input  logic             norm_found,
    input  logic [SRC_W-1:0] norm_src,
    output logic [31:0]      status
);
    // Layout: each half holds a found flag at its top and the source at its bottom.
    always_comb begin
        status                          = '0;
        status[HALF_W-1]                = fast_found;
        status[SRC_W-1:0]               = fast_src;
        status[2*HALF_W-1]              = norm_found;
        status[HALF_W+SRC_W-1:HALF_W]   = norm_src;
    end
endmodule

// File: rtl/prio_resolver.sv
// Module: top of the programmable priority resolver. Splits asserted sources
// into fast and normal classes, resolves each through the slot table and
// serves slot and status reads.
// Assumes pending, enable and class vectors come from the routing logic.
module prio_resolver
    import prio_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 40,
    parameter int unsigned LOW_BANK  = 32,
    parameter int unsigned NUM_SRC   = 40,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [NUM_SRC-1:0] src_pending,
    input  logic [NUM_SRC-1:0] src_enable,
    input  logic [NUM_SRC-1:0] src_fast
);
    slot_t [NUM_SLOTS-1:0] slots;
    logic                  tbl_hit;
    logic [31:0]           tbl_word;
    logic [NUM_SRC-1:0]    active, cand_fast, cand_norm;
    logic                  fast_found, norm_found;
    logic [SRC_W-1:0]      fast_src, norm_src;
    logic [31:0]           status;

    prio_slot_table #(.NUM_SLOTS(NUM_SLOTS), .LOW_BANK(LOW_BANK), .ADDR_W(ADDR_W)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .slots(slots), .hit(tbl_hit), .rd_word(tbl_word)
    );

    // Classify: asserted sources split by their class select bit.
    always_comb begin
        active    = src_pending & src_enable;
        cand_fast = active & src_fast;
        cand_norm = active & ~src_fast;
    end

    prio_winner_scan #(.NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC)) u_scan_fast (
        .clk(clk), .rst_n(rst_n), .slots(slots), .cand(cand_fast),
        .found(fast_found), .win_src(fast_src)
    );

    prio_winner_scan #(.NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC)) u_scan_norm (
        .clk(clk), .rst_n(rst_n), .slots(slots), .cand(cand_norm),
        .found(norm_found), .win_src(norm_src)
    );

    prio_status_pack u_pack (
        .fast_found(fast_found), .fast_src(fast_src),
        .norm_found(norm_found), .norm_src(norm_src), .status(status)
    );

    // Read mux: status word, slot word, or zero for unmapped offsets.
    always_comb begin
        if (32'(addr) == STATUS_OFS) rdata = status;
        else if (tbl_hit)           rdata = tbl_word;
        else                        rdata = '0;
    end

    AST_FAST_HALF_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        status[HALF_W-1] |-> (32'(status[SRC_W-1:0]) < NUM_SRC
            && src_pending[status[SRC_W-1:0]] && src_enable[status[SRC_W-1:0]]
            && src_fast[status[SRC_W-1:0]])); // R6
    AST_NORM_HALF_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        status[2*HALF_W-1] |-> (32'(status[HALF_W+SRC_W-1:HALF_W]) < NUM_SRC
            && src_pending[status[HALF_W+SRC_W-1:HALF_W]]
            && src_enable[status[HALF_W+SRC_W-1:HALF_W]]
            && !src_fast[status[HALF_W+SRC_W-1:HALF_W]])); // R6
    AST_HALF_ZERO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (status[HALF_W-2:SRC_W] == '0 && status[2*HALF_W-2:HALF_W+SRC_W] == '0)); // R7
    AST_EMPTY_FAST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        !status[HALF_W-1] |-> (status[HALF_W-1:0] == 16'h003F)); // R8
endmodule

// File: tb/prio_resolver_bench.sv
// Bench: sweeps the resolver with a slot-by-slot reference model.
module prio_resolver_bench;
    localparam int NS = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NS-1:0] pend = '0, en = '0, fast = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit          mv [NS];
    logic [5:0]  ms [NS];

    always #4 clk = ~clk;

    prio_resolver u_prio_resolver (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .src_pending(pend), .src_enable(en), .src_fast(fast)
    );

    function automatic logic [7:0] slot_ofs(int k);
        return (k < 32) ? 8'(8'h1C + 4 * k) : 8'(8'hB0 + 4 * (k - 32));
    endfunction

    function automatic logic [31:0] model_status();
        logic [15:0] fh = 16'h003F, nh = 16'h003F;
        bit fd = 0, nd = 0;
        for (int k = 0; k < NS; k++) begin
            if (mv[k] && ms[k] < 40 && pend[ms[k]] && en[ms[k]]) begin
                if (fast[ms[k]] && !fd) begin fd = 1; fh = 16'h8000 | 16'(ms[k]); end
                if (!fast[ms[k]] && !nd) begin nd = 1; nh = 16'h8000 | 16'(ms[k]); end
            end
        end
        return {nh, fh};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_slot(int k, logic [31:0] d);
        wr(slot_ofs(k), d);
        mv[k] = d[31];
        ms[k] = d[5:0];
    endtask

    task automatic chk_status(string req);
        logic [31:0] v;
        rd(8'h18, v);
        check(req, v, model_status());
    endtask

    task automatic chk_all_slots(string req);
        logic [31:0] v;
        for (int k = 0; k < NS; k++) begin
            rd(slot_ofs(k), v);
            check(req, v, {mv[k], 25'b0, ms[k]});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] lfsr = 32'h1ACE_B00C;
        for (int k = 0; k < NS; k++) begin mv[k] = 0; ms[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_all_slots("R1 slot after reset");
        pend = '1; en = '1; fast = 40'h00_FFFF_0000;
        rd(8'h18, v);
        check("R1 status after reset", v, 32'h003F003F);

        // R3: masking of written bits
        wr_slot(5, 32'hFFFF_FFFF);
        rd(slot_ofs(5), v);
        check("R3 all-ones write", v, 32'h8000003F);
        wr_slot(37, 32'h7FFF_FFC5);
        rd(slot_ofs(37), v);
        check("R3 flag clear write", v, 32'h00000005);

        // R2: distinct value per slot in both banks
        for (int k = 0; k < NS; k++)
            wr_slot(k, ((k % 2) ? 32'hC3A5_5A00 : 32'h0F0F_F000) | 32'((k * 7 + 3) % 64));
        chk_all_slots("R2 bank map readback");

        // R10: ignored writes and zero reads
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h1D, 32'hFFFF_FFFF);
        wr(8'hA0, 32'hFFFF_FFFF);
        wr(8'hD0, 32'hFFFF_FFFF);
        wr(8'hCF, 32'hFFFF_FFFF);
        chk_all_slots("R10 stray write");
        rd(8'h00, v); check("R10 read 0x00", v, 0);
        rd(8'h1D, v); check("R10 read unaligned", v, 0);
        rd(8'hA0, v); check("R10 read gap", v, 0);
        rd(8'hD0, v); check("R10 read past end", v, 0);

        // R6 R7 R8 R9: identity table, each source alone in each class
        for (int k = 0; k < NS; k++) wr_slot(k, 32'h8000_0000 | 32'(k));
        en = '1;
        for (int s = 0; s < NS; s++) begin
            pend = '0; pend[s] = 1'b1;
            fast = '0; chk_status("R6 single normal");
            fast[s] = 1'b1; chk_status("R7 single fast");
            en[s] = 1'b0; chk_status("R8 disabled source");
            en[s] = 1'b1;
        end
        pend = '0;
        rd(8'h18, v); check("R8 both halves empty", v, 32'h003F003F);

        // R5 R9: reversed table, every ordered source pair
        for (int k = 0; k < NS; k++) wr_slot(k, 32'h8000_0000 | 32'(NS - 1 - k));
        en = '1;
        for (int a = 0; a < NS; a++) begin
            for (int b = 0; b < NS; b++) begin
                pend = '0; pend[a] = 1'b1; pend[b] = 1'b1;
                fast = '0;
                if ((a + b) % 3 == 0) fast[a] = 1'b1;
                if ((a + b) % 3 == 1) fast[b] = 1'b1;
                chk_status("R5 source pair");
            end
        end

        // R4: invalid and out-of-range slots ahead of a legal one
        for (int k = 0; k < NS; k++) wr_slot(k, 32'h0000_0000);
        wr_slot(0, 32'h8000_003F);
        wr_slot(1, 32'h8000_0028);
        wr_slot(2, 32'h0000_0003);
        wr_slot(3, 32'h8000_0007);
        wr_slot(4, 32'h8000_0009);
        pend = '1; en = '1; fast = '1;
        rd(8'h18, v); check("R4 skip bad slots fast", v, 32'h003F8007);
        fast = '0;
        rd(8'h18, v); check("R4 skip bad slots normal", v, 32'h80073F3F & 32'h8007003F);

        // R5: duplicate source in two slots, lower slot decides
        wr_slot(10, 32'h8000_000C);
        wr_slot(20, 32'h8000_000C);
        wr_slot(3, 32'h0000_0000);
        wr_slot(4, 32'h0000_0000);
        pend = '0; pend[12] = 1'b1; fast = '0; fast[12] = 1'b1;
        rd(8'h18, v); check("R5 duplicate slots", v, 32'h003F800C);
        wr_slot(10, 32'h0000_0000);
        rd(8'h18, v); check("R5 duplicate fallback", v, 32'h003F800C);

        // R9: status tracks inputs with no clock edge
        pend = '0;
        rd(8'h18, v); check("R9 drop pending", v, 32'h003F003F);
        pend[12] = 1'b1; fast[12] = 1'b0;
        rd(8'h18, v); check("R9 same-cycle class flip", v, 32'h800C003F);

        // R5 R6: pseudo-random tables and vectors
        for (int it = 0; it < 400; it++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (it % 4 == 0)
                wr_slot(int'(lfsr[15:0]) % NS, {lfsr[31], 25'(lfsr[30:6]), lfsr[5:0]});
            pend = {lfsr[7:0], lfsr};
            en   = {lfsr[15:8], ~lfsr[31:0] ^ {lfsr[15:0], lfsr[31:16]}};
            fast = {lfsr[23:16], lfsr[30:0], lfsr[31]};
            chk_status("R5 random mix");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule